// File: doc/BRIEF.md
# Serial Two-Wire Register File Target

This block is an I2C target that runs entirely in the system clock domain. It brings the bus clock and data lines through a two-flop synchronizer, finds the bus conditions and clock edges, and answers to one fixed 7-bit identifier. Behind the bus sits a small array of 8-bit registers reached through a register pointer. The controller loads the pointer with the first byte of a write. After that it either streams data bytes into consecutive registers or starts a read that streams registers back out.

Write data is never applied byte by byte. Each acknowledged data byte goes into a staging buffer, and the whole buffer is copied into the register array only when a STOP closes the transfer. A transfer cut short keeps only the bytes that were fully received and acknowledged. A repeated START throws away whatever was staged. The pointer wraps from the last register to the first in both directions of transfer. Local logic reads the committed array through a plain combinational read port. SDA is driven only as an open-drain pull-down enable.

Top module: `i2c_rf_target`

## Requirements
- R1: While reset is high and after it is released, the SDA pull-down enable is low and every register reads 0x00 on the local port.
- R2: The first byte after a START carries the identifier 7'b1000100 in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). On a match the block pulls SDA low through the ninth SCL clock. On a mismatch it never pulls SDA low until the next START or STOP.
- R3: In a write, the block acknowledges the register-address byte and every data byte. Data bytes are shifted MSB first, and none of them reaches the array before the STOP.
- R4: During a burst write, each acknowledged data byte advances the pointer by one, and the pointer wraps from register 7 back to register 0.
- R5: A STOP that arrives before a data byte and its ACK are complete discards that byte. With no complete byte the array is unchanged; bytes completed earlier in the same burst are still committed.
- R6: A repeated START discards all staged write data, restarts identifier matching, and keeps the pointer where the write left it.
- R7: In a read, the block sends the register at the pointer MSB first, starting right after its identifier ACK. Each byte loaded for sending advances the pointer with wrap, and its pull-down enable stays constant while SCL is high.
- R8: A controller NACK after a read byte ends the read: SDA stays released for the remaining clocks, and the pointer has advanced only by the bytes sent.
- R9: For the first BOOT_CYCLES clocks after reset release, the block ignores START and STOP, so a transfer that begins in that window gets no ACK.
- R10: Only the low 3 bits of the register-address byte select a register; the upper bits have no effect.
- R11: The local read port returns the committed contents of the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull SDA low when high |
| loc_addr_i | input | 3 | Local read port register index |
| loc_rdata_o | output | 8 | Committed contents of the register at loc_addr_i |

## Verification
The directed cases cover a single-byte write, a burst that crosses the top register, an address byte with its upper bits set, a wrong identifier, and aborts inside the first and inside a later data byte. Together they separate staged data from committed data, check the wrap, and check which bytes survive an abort. A repeated START after a data byte, followed by a read, shows both that the staged bytes are discarded and that the pointer is kept. Seeded random transfers then mix bursts, reads, write-then-restart reads and foreign identifiers. Each read byte and each array snapshot is compared against a model of the register file and pointer.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int            BYTE_W        = 8;
    localparam logic [6:0]    DEF_TARGET_ID = 7'b1000100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } eng_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_lvl;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic may_drive(eng_state_t s);
        return (s == ST_ADDR_ACK) || (s == ST_REG_ACK) ||
               (s == ST_WR_ACK)   || (s == ST_RD);
    endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync
    import i2c_rf_pkg::*;
#(
    parameter int BOOT_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     scl_hi_o,
    output logic     boot_done_o
);
    localparam int BW = $clog2(BOOT_CYCLES + 2);

    // index 1 = SCL, index 0 = SDA
    logic [1:0]    meta_q;
    logic [1:0]    sync_q;
    logic [1:0]    prev_q;
    logic [BW-1:0] boot_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            boot_cnt <= '0;
        else if (!boot_done_o)
            boot_cnt <= boot_cnt + 1'b1;
    end

    assign boot_done_o = (boot_cnt == BW'(BOOT_CYCLES));

    logic scl_both_hi;
    assign scl_both_hi = sync_q[1] & prev_q[1];
    assign scl_hi_o    = scl_both_hi;

    always_comb begin
        evt_o          = '0;
        evt_o.sda_lvl  = sync_q[0];
        evt_o.scl_rise = boot_done_o &  sync_q[1] & ~prev_q[1];
        evt_o.scl_fall = boot_done_o & ~sync_q[1] &  prev_q[1];
        evt_o.start    = boot_done_o & scl_both_hi &  prev_q[0] & ~sync_q[0];
        evt_o.stop     = boot_done_o & scl_both_hi & ~prev_q[0] &  sync_q[0];
    end

endmodule

// File: rtl/i2c_rf_stage.sv
module i2c_rf_stage
    import i2c_rf_pkg::*;
#(
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         put_i,
    input  logic [AW-1:0]                put_idx_i,
    input  logic [BYTE_W-1:0]            put_data_i,
    input  logic                         clear_i,
    output logic [NREG-1:0]              vld_o,
    output logic [NREG-1:0][BYTE_W-1:0]  data_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                vld_o[i] <= 1'b0;
            end else if (put_i && (put_idx_i == AW'(i))) begin
                vld_o[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                data_o[i] <= '0;
            else if (put_i && (put_idx_i == AW'(i)))
                data_o[i] <= put_data_i;
        end
    end

endmodule

// File: rtl/i2c_rf_array.sv
module i2c_rf_array
    import i2c_rf_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit_i,
    input  logic [NREG-1:0]              vld_i,
    input  logic [NREG-1:0][BYTE_W-1:0]  data_i,
    output logic [NREG-1:0][BYTE_W-1:0]  regs_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[i] <= '0;
            else if (commit_i && vld_i[i])
                regs_o[i] <= data_i[i];
        end
    end

    AST_ARRAY_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (regs_o != $past(regs_o)) |-> $past(commit_i)) else $error("array changed without commit"); // R3

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] TARGET_ID = DEF_TARGET_ID,
    parameter int         NREG      = 8,
    localparam int        AW        = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt_i,
    input  logic              scl_hi_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [AW-1:0]     ptr_o,
    output logic              put_o,
    output logic [AW-1:0]     put_idx_o,
    output logic [BYTE_W-1:0] put_data_o,
    output logic              commit_o,
    output logic              discard_o,
    output logic              sda_oe_o
);

    eng_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] wbyte;
    logic [2:0]        bitcnt;
    logic              full;
    logic              rw;
    logic              mack;
    logic [AW-1:0]     ptr;
    logic [AW-1:0]     ptr_nxt;

    always_comb begin
        ptr_nxt = (ptr == AW'(NREG - 1)) ? '0 : ptr + 1'b1;
    end

    assign ptr_o = ptr;

    always_ff @(posedge clk) begin
        put_o     <= 1'b0;
        commit_o  <= 1'b0;
        discard_o <= 1'b0;
        if (rst) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            wbyte      <= '0;
            bitcnt     <= '0;
            full       <= 1'b0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            ptr        <= '0;
            put_idx_o  <= '0;
            put_data_o <= '0;
            sda_oe_o   <= 1'b0;
        end else if (evt_i.start) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            full      <= 1'b0;
            sda_oe_o  <= 1'b0;
            discard_o <= 1'b1;
        end else if (evt_i.stop) begin
            state    <= ST_IDLE;
            full     <= 1'b0;
            sda_oe_o <= 1'b0;
            commit_o <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR, ST_REG, ST_WR: begin
                    if (evt_i.scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], evt_i.sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7)
                            full <= 1'b1;
                    end else if (evt_i.scl_fall && full) begin
                        full <= 1'b0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == TARGET_ID) begin
                                rw       <= shreg[0];
                                sda_oe_o <= 1'b1;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_REG) begin
                            ptr      <= shreg[AW-1:0];
                            sda_oe_o <= 1'b1;
                            state    <= ST_REG_ACK;
                        end else begin
                            wbyte    <= shreg;
                            sda_oe_o <= 1'b1;
                            state    <= ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        if (rw) begin
                            shreg    <= rdata_i;
                            sda_oe_o <= ~rdata_i[BYTE_W-1];
                            ptr      <= ptr_nxt;
                            bitcnt   <= '0;
                            state    <= ST_RD;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_REG;
                        end
                    end
                end
                ST_REG_ACK: begin
                    if (evt_i.scl_fall) begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_WR;
                    end
                end
                ST_WR_ACK: begin
                    if (evt_i.scl_fall) begin
                        sda_oe_o   <= 1'b0;
                        put_o      <= 1'b1;
                        put_idx_o  <= ptr;
                        put_data_o <= wbyte;
                        ptr        <= ptr_nxt;
                        state      <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (evt_i.scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe_o <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_RD_ACK;
                        end else begin
                            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe_o <= ~shreg[BYTE_W-2];
                            bitcnt   <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt_i.scl_rise) begin
                        mack <= ~evt_i.sda_lvl;
                    end else if (evt_i.scl_fall) begin
                        if (mack) begin
                            shreg    <= rdata_i;
                            sda_oe_o <= ~rdata_i[BYTE_W-1];
                            ptr      <= ptr_nxt;
                            state    <= ST_RD;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DRIVE_ONLY_IN_OWN_SLOT: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> may_drive(state)) else $error("SDA pulled outside ACK or read slot"); // R2

    AST_DRIVE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_hi_i && !$past(evt_i.start || evt_i.stop)) |-> $stable(sda_oe_o)) else $error("SDA drive moved while SCL high"); // R7

    AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_ACK && evt_i.scl_fall && !evt_i.start && !evt_i.stop &&
         ptr == AW'(NREG - 1)) |=> (ptr == '0)) else $error("pointer did not wrap"); // R4

    AST_NO_PUT_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> !put_o) else $error("stage write collides with commit"); // R5

endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] TARGET_ID   = DEF_TARGET_ID,
    parameter int         NREG        = 8,
    parameter int         BOOT_CYCLES = 16,
    localparam int        AW          = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [AW-1:0]     loc_addr_i,
    output logic [BYTE_W-1:0] loc_rdata_o
);

    bus_evt_t                      evt;
    logic                          scl_hi;
    logic                          boot_done;
    logic [AW-1:0]                 ptr;
    logic                          put;
    logic [AW-1:0]                 put_idx;
    logic [BYTE_W-1:0]             put_data;
    logic                          commit;
    logic                          discard;
    logic [NREG-1:0]               stg_vld;
    logic [NREG-1:0][BYTE_W-1:0]   stg_data;
    logic [NREG-1:0][BYTE_W-1:0]   regs;

    i2c_rf_sync #(.BOOT_CYCLES(BOOT_CYCLES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .evt_o       (evt),
        .scl_hi_o    (scl_hi),
        .boot_done_o (boot_done)
    );

    i2c_rf_engine #(.TARGET_ID(TARGET_ID), .NREG(NREG)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .scl_hi_i   (scl_hi),
        .rdata_i    (regs[ptr]),
        .ptr_o      (ptr),
        .put_o      (put),
        .put_idx_o  (put_idx),
        .put_data_o (put_data),
        .commit_o   (commit),
        .discard_o  (discard),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_rf_stage #(.NREG(NREG)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .put_i      (put),
        .put_idx_i  (put_idx),
        .put_data_i (put_data),
        .clear_i    (commit | discard),
        .vld_o      (stg_vld),
        .data_o     (stg_data)
    );

    i2c_rf_array #(.NREG(NREG)) u_array (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .vld_i    (stg_vld),
        .data_i   (stg_data),
        .regs_o   (regs)
    );

    assign loc_rdata_o = regs[loc_addr_i];

    AST_SILENT_DURING_BOOT: assert property (@(posedge clk) disable iff (rst)
        !boot_done |-> !sda_oe_o) else $error("drove SDA during boot window"); // R9

    AST_DISCARD_EMPTIES_STAGE: assert property (@(posedge clk) disable iff (rst)
        $past(discard) |-> (stg_vld == '0)) else $error("stage kept data after restart"); // R6

endmodule

// File: tb/i2c_rf_target_tb.sv
module i2c_rf_target_tb;

    localparam int         H     = 16;
    localparam int         BOOT  = 16;
    localparam logic [6:0] ID    = 7'b1000100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m_oe = 1'b0;
    logic       dut_oe;
    logic       sda_bus;
    logic [2:0] loc_addr = '0;
    logic [7:0] loc_rdata;

    assign sda_bus = ~(sda_m_oe | dut_oe);

    always #4 clk = ~clk;

    i2c_rf_target u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (dut_oe),
        .loc_addr_i  (loc_addr),
        .loc_rdata_o (loc_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] mdl [8];
    logic [7:0] stg [8];
    bit         stv [8];
    int         mptr = 0;

    function automatic int wrap_add(int p, int n);
        return (p + n) % 8;
    endfunction

    function automatic logic [7:0] id_byte(logic [6:0] id, bit rd);
        return {id, rd};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_start();
        sda_m_oe = 1'b1; tick(H);
        scl_m = 1'b0;    tick(H);
    endtask

    task automatic m_restart();
        sda_m_oe = 1'b0; tick(H);
        scl_m = 1'b1;    tick(H);
        sda_m_oe = 1'b1; tick(H);
        scl_m = 1'b0;    tick(H);
    endtask

    task automatic m_stop();
        sda_m_oe = 1'b1; tick(H);
        scl_m = 1'b1;    tick(H);
        sda_m_oe = 1'b0; tick(H);
    endtask

    task automatic m_bit_out(bit b);
        sda_m_oe = !b; tick(H);
        scl_m = 1'b1;  tick(H);
        scl_m = 1'b0;  tick(2);
    endtask

    task automatic m_bit_in(output bit b);
        sda_m_oe = 1'b0; tick(H);
        scl_m = 1'b1;    tick(H / 2);
        b = sda_bus;     tick(H / 2);
        scl_m = 1'b0;    tick(2);
    endtask

    task automatic m_byte_out(logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(b);
        ack = !b;
    endtask

    task automatic m_byte_in(bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(b);
            v[i] = b;
        end
        m_bit_out(!give_ack);
    endtask

    task automatic stage_clear();
        for (int i = 0; i < 8; i++) stv[i] = 1'b0;
    endtask

    task automatic stage_commit();
        for (int i = 0; i < 8; i++) if (stv[i]) mdl[i] = stg[i];
        stage_clear();
    endtask

    task automatic chk_array(string req);
        tick(4);
        for (int i = 0; i < 8; i++) begin
            loc_addr = 3'(i);
            tick(1);
            chk(loc_rdata == mdl[i], req, loc_rdata, mdl[i]);
        end
    endtask

    // Address phase of a write: identifier plus register byte.
    task automatic wr_head(logic [7:0] rbyte);
        bit ack;
        m_start();
        m_byte_out(id_byte(ID, 1'b0), ack);
        chk(ack, "R2 id ack (write)", ack, 1);
        m_byte_out(rbyte, ack);
        chk(ack, "R3 reg byte ack", ack, 1);
        mptr = int'(rbyte[2:0]);
        stage_clear();
    endtask

    task automatic wr_data(logic [7:0] d);
        bit ack;
        m_byte_out(d, ack);
        chk(ack, "R3 data ack", ack, 1);
        stg[mptr] = d;
        stv[mptr] = 1'b1;
        mptr = wrap_add(mptr, 1);
    endtask

    task automatic wr_burst(logic [7:0] rbyte, int n);
        int first;
        wr_head(rbyte);
        first = mptr;
        for (int k = 0; k < n; k++) begin
            wr_data(8'($urandom));
            if (k == 0) begin
                loc_addr = 3'(first);
                tick(6);
                chk(loc_rdata == mdl[first], "R3 no commit before STOP", loc_rdata, mdl[first]);
            end
        end
        m_stop();
        stage_commit();
        chk_array("R11 array after write");
    endtask

    // Read body after a matched read identifier.
    task automatic rd_body(int n);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            m_byte_in(k < n - 1, v);
            chk(v == mdl[mptr], "R7 read byte", v, mdl[mptr]);
            mptr = wrap_add(mptr, 1);
        end
    endtask

    task automatic rd_burst(int n);
        bit ack;
        m_start();
        m_byte_out(id_byte(ID, 1'b1), ack);
        chk(ack, "R2 id ack (read)", ack, 1);
        rd_body(n);
        m_stop();
    endtask

    task automatic foreign_id();
        bit         ack;
        logic [6:0] other;
        other = 7'($urandom);
        if (other == ID) other = other ^ 7'h01;
        m_start();
        m_byte_out(id_byte(other, 1'($urandom)), ack);
        chk(!ack, "R2 foreign id not acked", ack, 0);
        m_byte_out(8'h00, ack);
        chk(!ack, "R2 stays released after mismatch", ack, 0);
        m_stop();
        chk(dut_oe == 1'b0, "R2 released", dut_oe, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit         ack;
        bit         b;
        logic [7:0] v;
        int         seed;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        stage_clear();

        tick(5);
        chk(dut_oe == 1'b0, "R1 no drive in reset", dut_oe, 0);
        rst = 1'b0;
        tick(1);

        // R9: transfer begun inside the boot window is ignored
        m_start();
        m_byte_out(id_byte(ID, 1'b0), ack);
        chk(!ack, "R9 START in boot window ignored", ack, 0);
        m_stop();

        chk_array("R1 registers zero after reset");

        // R3: single byte write
        wr_burst(8'h02, 1);
        // R4: burst across the top register
        wr_burst(8'h06, 4);
        chk(mptr == 2, "R4 pointer wrapped", mptr, 2);
        // R10: upper address bits ignored
        wr_burst(8'hF5, 1);

        // R2: foreign identifier
        foreign_id();

        // R5: abort inside first data byte
        wr_head(8'h03);
        for (int i = 0; i < 4; i++) m_bit_out(1'b1);
        m_stop();
        stage_clear();
        chk_array("R5 abort in first byte leaves array");

        // R5: abort inside second byte of burst keeps first
        wr_head(8'h04);
        wr_data(8'hA5);
        for (int i = 0; i < 5; i++) m_bit_out(1'b0);
        m_stop();
        stage_commit();
        chk_array("R5 completed byte commits, partial dropped");

        // R6: repeated START discards staged data, pointer kept
        wr_head(8'h01);
        wr_data(8'h3C);
        m_restart();
        stage_clear();
        m_byte_out(id_byte(ID, 1'b1), ack);
        chk(ack, "R6 identifier re-matched after restart", ack, 1);
        rd_body(1);
        m_stop();
        chk_array("R6 staged data discarded");

        // R7/R8: read across wrap, NACK ends the read
        wr_burst(8'h07, 1);
        wr_head(8'h06);
        m_restart();
        m_byte_out(id_byte(ID, 1'b1), ack);
        chk(ack, "R7 read after pointer set", ack, 1);
        rd_body(4);
        chk(mptr == 2, "R8 pointer after NACK", mptr, 2);
        m_bit_in(b);
        chk(b == 1'b1, "R8 SDA released after NACK", b, 1);
        m_bit_in(b);
        chk(b == 1'b1, "R8 SDA released after NACK", b, 1);
        m_stop();
        rd_burst(1);

        // constrained random mix
        for (int t = 0; t < 25; t++) begin
            int kind;
            kind = int'($urandom % 4);
            case (kind)
                0: wr_burst(8'($urandom), 1 + int'($urandom % 6));
                1: rd_burst(1 + int'($urandom % 5));
                2: begin
                    wr_head(8'($urandom));
                    m_restart();
                    m_byte_out(id_byte(ID, 1'b1), ack);
                    chk(ack, "R7 restart read ack", ack, 1);
                    rd_body(1 + int'($urandom % 4));
                    m_stop();
                end
                default: foreign_id();
            endcase
        end
        chk_array("R11 final array");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule